// File: doc/BRIEF.md
# Two-wire management link master

This block drives a two-wire serial management link toward a switch device. It owns a clock output and a data line that it drives or releases, shown as separate data-out, drive-enable and data-in pins for a pad cell to merge. A host places one request at a time: a read/write flag, a 16-bit register address and, for writes, 16 bits of data. The block frames the transaction, collects the acknowledges, and ends with a one-cycle done pulse, an error flag and, for reads, the 16-bit result.

A transaction is a start sequence, a command byte, the address in two bytes, then either two data bytes sent or two data bytes received, and a stop sequence with trailing clocks. Each acknowledge the device owes is polled: a busy device answers 1 and the slot is repeated, up to a parameter limit. Link timing comes from a parameter that sets the number of system clocks in one half period of the link clock.

Top module: `mgmt2w_master`

## Requirements
- R1: Out of reset and whenever busy is low, both the clock and data drive enables are low and busy, done and err are low after reset.
- R2: A transaction begins with the clock low and data high, then one clock pulse with data high, then a second pulse during which data falls while the clock is high; this is the only data fall with the clock high in a transaction.
- R3: The first eight transmitted bits are 1, 0, 1, 1, 1, 0, 0 and then the direction bit, 1 for read and 0 for write.
- R4: Every bit slot lasts three half periods: clock low, clock high, clock low; a transmitted bit is placed while the clock is low and held steady while it is high.
- R5: In acknowledge slots and received-data slots the data drive enable is low, and the data line is sampled at the end of the clock-high half.
- R6: An acknowledge of 0 is accepted; an acknowledge of 1 repeats the slot until 0 is seen or ACK_TRIES slots have been read; reaching the limit with 1 sets err, the transaction still runs to its stop, and err stays set until the next request is accepted.
- R7: Acknowledges follow the command byte and both address bytes; the address goes out as bits [7:0] then [15:8], and write data as bits [7:0] then [15:8], each byte most significant bit first; a write also polls an acknowledge after each data byte.
- R8: A read receives bits [7:0] then [15:8], each most significant bit first, drives a 0 acknowledge after the first byte and a 1 after the second, and presents the word on rd_data.
- R9: The stop drives data low as the clock rises, raises data with the clock high, then gives two more low/high clock pulses, after which both lines are released.
- R10: busy rises on the edge a request is accepted and falls on the edge done pulses for one cycle; done comes (14 + 3*(45 + R)) * HALF_CYC clock cycles after acceptance, R being the number of repeated acknowledge slots.
- R11: A request presented while busy is ignored: the running transaction is not altered and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_rd | input | 1 | 1 for read, 0 for write |
| req_addr | input | 16 | Device register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | An acknowledge hit the retry limit |
| rd_data | output | 16 | Word received by the last read |
| scl_o | output | 1 | Link clock level |
| scl_oe | output | 1 | Link clock drive enable |
| sda_o | output | 1 | Data level when driven |
| sda_oe | output | 1 | Data drive enable |
| sda_i | input | 1 | Data line level from the pad |

## Verification
Every result of a transaction is due on the same edge: done, the fall of busy, the final err and rd_data all settle (14 + 3*(45 + R)) * HALF_CYC cycles after the accepting edge, so the bench counts cycles from that edge and compares the count where done is first seen at a falling clock edge. The device model watches the link at falling system-clock edges, logging each rising link clock with its drive state and data, and places its answer right after the rise, a full half period before the master samples. Line checks compare that log entry by entry against a sequence built from the requirements, and the idle release and done width are checked one cycle after done.

// File: rtl/mgmt2w_pkg.sv
package mgmt2w_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_TX    = 3'd2,
    PH_RX    = 3'd3,
    PH_ACK   = 3'd4,
    PH_STOP  = 3'd5
  } phase_t;

  typedef struct packed {
    logic scl_oe;
    logic scl;
    logic sda_oe;
    logic sda;
  } pins_t;

  // leading control pattern sent ahead of the direction bit
  localparam logic [6:0] LEAD_CODE      = 7'b1011100;
  localparam logic [2:0] FRAME_END_STEP = 3'd6;
  localparam logic [2:0] SLOT_HIGH_STEP = 3'd1;
  localparam logic [2:0] SLOT_END_STEP  = 3'd2;

  // Field order: 0 command, 1 addr low, 2 addr high,
  // write: 3 data low, 4 data high
  // read : 3 rx low, 4 master ack 0, 5 rx high, 6 master ack 1
  function automatic logic fld_is_rx(input logic rd, input logic [2:0] f);
    return rd && (f == 3'd3 || f == 3'd5);
  endfunction

  function automatic logic fld_is_bit(input logic rd, input logic [2:0] f);
    return rd && (f == 3'd4 || f == 3'd6);
  endfunction

  function automatic logic fld_has_ack(input logic rd, input logic [2:0] f);
    return (f <= 3'd2) || (!rd && f <= 3'd4);
  endfunction

  function automatic logic fld_is_last(input logic rd, input logic [2:0] f);
    return rd ? (f == 3'd6) : (f == 3'd4);
  endfunction

  function automatic logic [7:0] fld_byte(input logic rd, input logic [2:0] f,
                                          input logic [15:0] a, input logic [15:0] d);
    logic [7:0] b;
    case (f)
      3'd0:    b = {LEAD_CODE, rd};
      3'd1:    b = a[7:0];
      3'd2:    b = a[15:8];
      3'd3:    b = d[7:0];
      3'd4:    b = rd ? 8'h00 : d[15:8];
      3'd6:    b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/mgmt2w_rst_sync.sv
module mgmt2w_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mgmt2w_tick.sv
module mgmt2w_tick #(
  parameter int HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!run || cnt_q == CNT_LAST) cnt_n = '0;
    else                           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = run && (cnt_q == CNT_LAST);
endmodule

// File: rtl/mgmt2w_pins.sv
module mgmt2w_pins
  import mgmt2w_pkg::*;
(
  input  phase_t     ph,
  input  logic [2:0] stp,
  input  logic       txb,
  output pins_t      pins
);
  always_comb begin
    pins = '{scl_oe: 1'b0, scl: 1'b0, sda_oe: 1'b0, sda: 1'b1};
    case (ph)
      PH_START: begin
        pins.scl_oe = 1'b1;
        pins.sda_oe = 1'b1;
        pins.scl    = (stp == 3'd1) || (stp == 3'd3) || (stp == 3'd4);
        pins.sda    = !((stp == 3'd4) || (stp == 3'd5));
      end
      PH_TX: begin
        pins.scl_oe = 1'b1;
        pins.sda_oe = 1'b1;
        pins.scl    = (stp == SLOT_HIGH_STEP);
        pins.sda    = txb;
      end
      PH_RX, PH_ACK: begin
        pins.scl_oe = 1'b1;
        pins.scl    = (stp == SLOT_HIGH_STEP);
      end
      PH_STOP: begin
        pins.scl_oe = 1'b1;
        pins.sda_oe = 1'b1;
        pins.scl    = !((stp == 3'd3) || (stp == 3'd5));
        pins.sda    = (stp != 3'd0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mgmt2w_master.sv
module mgmt2w_master
  import mgmt2w_pkg::*;
#(
  parameter int HALF_CYC  = 50,
  parameter int ACK_TRIES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_rd,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data,
  output logic        scl_o,
  output logic        scl_oe,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam int TW = $clog2(ACK_TRIES + 1);
  localparam logic [TW-1:0] TRY_MAX = TW'(ACK_TRIES);
  localparam logic [TW-1:0] TRY_ONE = TW'(1);

  logic        rst_n_s;
  phase_t      ph_q, ph_n;
  logic [2:0]  stp_q, stp_n, bit_q, bit_n, fld_q, fld_n, fld_inc;
  logic [TW-1:0] try_q, try_n;
  logic        rd_q;
  logic [15:0] addr_q, wd_q, rdat_q, rdat_n;
  logic        err_q, err_n, done_q, done_n, ackv_q, ackv_n;
  logic        tick, accept, adv, go_next, txb_n;
  logic [7:0]  tx_byte;
  pins_t       pins_q, pins_n;

  mgmt2w_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  mgmt2w_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n_s),
    .run  (busy),
    .tick (tick)
  );

  assign busy    = (ph_q != PH_IDLE);
  assign accept  = !busy && req_valid;
  assign adv     = accept || tick;
  assign fld_inc = fld_q + 3'd1;

  // next-state process
  always_comb begin
    ph_n    = ph_q;
    stp_n   = stp_q;
    bit_n   = bit_q;
    fld_n   = fld_q;
    try_n   = try_q;
    rdat_n  = rdat_q;
    err_n   = err_q;
    ackv_n  = ackv_q;
    done_n  = 1'b0;
    go_next = 1'b0;
    if (accept) begin
      ph_n  = PH_START;
      stp_n = 3'd0;
      err_n = 1'b0;
    end else if (tick) begin
      case (ph_q)
        PH_START: begin
          if (stp_q == FRAME_END_STEP) begin
            ph_n  = PH_TX;
            stp_n = 3'd0;
            fld_n = 3'd0;
            bit_n = 3'd7;
          end else begin
            stp_n = stp_q + 3'd1;
          end
        end
        PH_TX, PH_RX: begin
          if (stp_q != SLOT_END_STEP) begin
            stp_n = stp_q + 3'd1;
            if (ph_q == PH_RX && stp_q == SLOT_HIGH_STEP)
              rdat_n[{fld_q[2], bit_q}] = sda_i;
          end else if (bit_q != 3'd0) begin
            bit_n = bit_q - 3'd1;
            stp_n = 3'd0;
          end else if (fld_has_ack(rd_q, fld_q)) begin
            ph_n  = PH_ACK;
            stp_n = 3'd0;
            try_n = TRY_ONE;
          end else begin
            go_next = 1'b1;
          end
        end
        PH_ACK: begin
          if (stp_q != SLOT_END_STEP) begin
            stp_n = stp_q + 3'd1;
            if (stp_q == SLOT_HIGH_STEP) ackv_n = sda_i;
          end else if (!ackv_q) begin
            go_next = 1'b1;
          end else if (try_q == TRY_MAX) begin
            err_n   = 1'b1;
            go_next = 1'b1;
          end else begin
            try_n = try_q + TRY_ONE;
            stp_n = 3'd0;
          end
        end
        PH_STOP: begin
          if (stp_q == FRAME_END_STEP) begin
            ph_n   = PH_IDLE;
            stp_n  = 3'd0;
            done_n = 1'b1;
          end else begin
            stp_n = stp_q + 3'd1;
          end
        end
        default: ;
      endcase
      if (go_next) begin
        stp_n = 3'd0;
        if (fld_is_last(rd_q, fld_q)) begin
          ph_n = PH_STOP;
        end else begin
          fld_n = fld_inc;
          ph_n  = fld_is_rx(rd_q, fld_inc) ? PH_RX : PH_TX;
          bit_n = fld_is_bit(rd_q, fld_inc) ? 3'd0 : 3'd7;
        end
      end
    end
  end

  assign tx_byte = fld_byte(rd_q, fld_n, addr_q, wd_q);
  assign txb_n   = tx_byte[bit_n];

  mgmt2w_pins u_pins (
    .ph  (ph_n),
    .stp (stp_n),
    .txb (txb_n),
    .pins(pins_n)
  );

  // register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ph_q   <= PH_IDLE;
      stp_q  <= 3'd0;
      bit_q  <= 3'd0;
      fld_q  <= 3'd0;
      try_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rdat_q <= '0;
      err_q  <= 1'b0;
      ackv_q <= 1'b0;
      done_q <= 1'b0;
      pins_q <= '{scl_oe: 1'b0, scl: 1'b0, sda_oe: 1'b0, sda: 1'b1};
    end else begin
      done_q <= done_n;
      pins_q <= pins_n;
      if (adv) begin
        ph_q   <= ph_n;
        stp_q  <= stp_n;
        bit_q  <= bit_n;
        fld_q  <= fld_n;
        try_q  <= try_n;
        rdat_q <= rdat_n;
        err_q  <= err_n;
        ackv_q <= ackv_n;
      end
      if (accept) begin
        rd_q   <= req_rd;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
      end
    end
  end

  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rdat_q;
  assign scl_o   = pins_q.scl;
  assign scl_oe  = pins_q.scl_oe;
  assign sda_o   = pins_q.sda;
  assign sda_oe  = pins_q.sda_oe;
endmodule

// File: rtl/mgmt2w_master_chk.sv
module mgmt2w_master_chk
  import mgmt2w_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_t ph,
  input logic   busy,
  input logic   done,
  input logic   err,
  input logic   scl_o,
  input logic   scl_oe,
  input logic   sda_o,
  input logic   sda_oe
);
  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  tx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TX && $past(ph) == PH_TX && scl_o && $past(scl_o)) |-> $stable(sda_o));

  // R5
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RX || ph == PH_ACK) |-> !sda_oe);

  // R6
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> busy);

  // R9
  stop_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOP) |-> (scl_oe && sda_oe));
endmodule

bind mgmt2w_master mgmt2w_master_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ph    (ph_q),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .scl_o (scl_o),
  .scl_oe(scl_oe),
  .sda_o (sda_o),
  .sda_oe(sda_oe)
);

// File: tb/mgmt2w_master_bench.sv
`timescale 1ns/1ps
module mgmt2w_master_bench;
  localparam int HALF  = 4;
  localparam int TRIES = 5;
  localparam int NVEC  = 7;
  localparam int VW    = 54;

  // {rd, addr, wdata, device read word, nacks on command ack, expected err}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {1'b0, 16'h1234, 16'hABCD, 16'h0000, 4'd0, 1'b0},
    {1'b1, 16'h00FF, 16'h0000, 16'h5A3C, 4'd0, 1'b0},
    {1'b0, 16'hFFFF, 16'h0000, 16'h0000, 4'd2, 1'b0},
    {1'b1, 16'h8001, 16'h0000, 16'hFFFF, 4'd4, 1'b0},
    {1'b0, 16'h0000, 16'hFFFF, 16'h0000, 4'd5, 1'b1},
    {1'b1, 16'hA5C3, 16'h0000, 16'h0001, 4'd0, 1'b0},
    {1'b1, 16'h7E81, 16'h0000, 16'h8000, 4'd5, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_rd = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, err, scl_o, scl_oe, sda_o, sda_oe, sda_i;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  mgmt2w_master #(.HALF_CYC(HALF), .ACK_TRIES(TRIES)) u_mgmt2w_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .scl_o(scl_o), .scl_oe(scl_oe),
    .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // device model
  logic resp_bit = 1'b1;
  logic q [0:63];
  int rp = 0, rn = 0, ln = 0, start_evt = 0, stop_evt = 0;
  logic [1:0] tr [0:127];
  logic prev_scl = 1'b0, prev_sda = 1'b1, mon_line;

  assign sda_i = sda_oe ? sda_o : resp_bit;

  always @(negedge clk) begin
    mon_line = sda_oe ? sda_o : 1'b1;
    if (scl_oe && !prev_scl && scl_o) begin
      if (ln < 128) tr[ln] = {sda_oe, sda_oe & sda_o};
      ln = ln + 1;
      if (!sda_oe) begin
        resp_bit = (rp < rn) ? q[rp] : 1'b1;
        rp = rp + 1;
      end
    end
    if (scl_oe && scl_o && prev_scl && prev_sda && !mon_line) start_evt = start_evt + 1;
    if (scl_oe && scl_o && prev_scl && !prev_sda && mon_line) stop_evt = stop_evt + 1;
    prev_scl = scl_oe & scl_o;
    prev_sda = mon_line;
  end

  logic [1:0] ex [0:127];
  int en = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] v);
    ex[en] = v;
    en++;
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) push({1'b1, b[i]});
  endtask

  task automatic run_vec(input int vi, input bit inject);
    logic [VW-1:0] v;
    logic rd, ee;
    logic [15:0] addr, wd, sr;
    logic [3:0] nk;
    int extra, cyc, busy_bad, exp_lat;
    bit got;
    bit [4:0] bad;
    v = VECS[vi];
    rd = v[53]; addr = v[52:37]; wd = v[36:21]; sr = v[20:5]; nk = v[4:1]; ee = v[0];
    extra = (int'(nk) >= TRIES) ? TRIES - 1 : int'(nk);
    // device answers
    rn = 0;
    for (int i = 0; i < int'(nk); i++) begin q[rn] = 1'b1; rn++; end
    if (int'(nk) < TRIES) begin q[rn] = 1'b0; rn++; end
    q[rn] = 1'b0; rn++;
    q[rn] = 1'b0; rn++;
    if (!rd) begin
      q[rn] = 1'b0; rn++;
      q[rn] = 1'b0; rn++;
    end else begin
      for (int i = 7; i >= 0; i--) begin q[rn] = sr[i]; rn++; end
      for (int i = 15; i >= 8; i--) begin q[rn] = sr[i]; rn++; end
    end
    // expected rising-clock trace: {driven, level}
    en = 0;
    push(2'b11); push(2'b11);
    push_byte({7'b1011100, rd});
    for (int i = 0; i <= extra; i++) push(2'b00);
    push_byte(addr[7:0]); push(2'b00);
    push_byte(addr[15:8]); push(2'b00);
    if (!rd) begin
      push_byte(wd[7:0]); push(2'b00);
      push_byte(wd[15:8]); push(2'b00);
    end else begin
      for (int i = 0; i < 8; i++) push(2'b00);
      push(2'b10);
      for (int i = 0; i < 8; i++) push(2'b00);
      push(2'b11);
    end
    push(2'b10); push(2'b11); push(2'b11);
    exp_lat = (14 + 3 * (45 + extra)) * HALF;

    @(negedge clk);
    ln = 0; rp = 0; start_evt = 0; stop_evt = 0;
    req_valid = 1'b1; req_rd = rd; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    cyc = 0; busy_bad = 0; got = 1'b0;
    while (!got && cyc < 20000) begin
      @(negedge clk);
      req_valid = inject && (cyc == 30);
      if (inject && cyc == 30) begin req_addr = ~addr; req_rd = ~rd; end
      if (done) got = 1'b1;
      else begin
        if (!busy) busy_bad++;
        cyc++;
      end
    end
    check(got, "R10 done seen", 32'(got), 32'd1);
    check(cyc == exp_lat, "R10 done latency", 32'(cyc), 32'(exp_lat));
    check(busy_bad == 0, "R10 busy held", 32'(busy_bad), 32'd0);
    check(!busy, "R10 busy low at done", 32'(busy), 32'd0);
    check(err == ee, "R6 err flag", 32'(err), 32'(ee));
    if (rd) check(rd_data == sr, "R8 read word", 32'(rd_data), 32'(sr));
    check(ln == en, "R7 clock pulse count", 32'(ln), 32'(en));
    bad = '0;
    for (int i = 0; i < en && i < ln && i < 128; i++) begin
      if (tr[i] != ex[i]) begin
        if (i < 2) bad[0] = 1'b1;
        else if (i < 10) bad[1] = 1'b1;
        else if (i >= en - 3) bad[4] = 1'b1;
        else if (ex[i] == 2'b00) bad[2] = 1'b1;
        else bad[3] = 1'b1;
      end
    end
    check(!bad[0], "R2 start pulses", 32'(bad[0]), 32'd0);
    check(!bad[1], "R3 command bits", 32'(bad[1]), 32'd0);
    check(!bad[2], "R5 released slots", 32'(bad[2]), 32'd0);
    check(!bad[3], "R7 byte order", 32'(bad[3]), 32'd0);
    check(!bad[4], "R9 stop pulses", 32'(bad[4]), 32'd0);
    check(start_evt == 1, "R2 start condition", 32'(start_evt), 32'd1);
    check(stop_evt == 1, "R9 stop condition", 32'(stop_evt), 32'd1);
    @(negedge clk);
    check(!done, "R10 done one cycle", 32'(done), 32'd0);
    check(!scl_oe && !sda_oe, "R9 lines released", 32'({scl_oe, sda_oe}), 32'd0);
    if (inject) begin
      repeat (3 * HALF) @(negedge clk);
      check(!busy && ln == en, "R11 request while busy ignored", 32'(busy), 32'd0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done, "R1 reset busy/done", 32'({busy, done}), 32'd0);
    check(!err, "R1 reset err", 32'(err), 32'd0);
    check(!scl_oe && !sda_oe, "R1 reset lines", 32'({scl_oe, sda_oe}), 32'd0);
    for (int vi = 0; vi < NVEC; vi++) run_vec(vi, vi == 2);
    // err is held after a failed transaction while idle
    repeat (10) @(negedge clk);
    check(err && !busy, "R6 err held while idle", 32'(err), 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule